// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog with a down-counter that advances on a count-enable tick. When the counter expires for the first time it raises an interrupt and starts a fresh period from the programmed reload value. If the counter expires again while that interrupt is still pending, it drives a system reset. Software keeps the system alive by rewriting the reload value or by clearing the interrupt. Either action restarts the period.

Software reaches the block over a single-cycle register bus. Read data is combinational from the address. A write takes effect at the clock edge on which the write enable is high. Every register write other than one to the key register is refused until a magic key has been written to the key register. Any other value written to the key register closes access again.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, the key register reads 1 (locked), the reload register at 0x000 reads 0xFFFFFFFF, control at 0x008 reads 0, the count at 0x004 reads 0xFFFFFFFF, the status bits read 0, and both irq_o and sys_rst_o are low.
- R2: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and offset 0xC00 then reads 0. Writing any other value there locks the block, and offset 0xC00 then reads 1.
- R3: While the block is locked, writes to the reload register, the control register and the interrupt-clear register are ignored. The reload value, control, count and status all keep their values.
- R4: While control bit 0 is set, each cycle with cnt_tick high decrements the count. Cycles without a tick, and any cycle with bit 0 clear, leave the count unchanged. A period starting from reload value L lasts exactly L+1 ticks.
- R5: A tick that arrives while the count is 0 sets bit 0 of the raw status (0x010) and reloads the count from the reload register.
- R6: If an expiry occurs while raw status is already 1 and control bit 1 is set, sys_rst_o goes high. It stays high until the block is reset. With control bit 1 clear, sys_rst_o never rises.
- R7: An accepted write to 0x000 stores the value and loads it into the count on the same edge. A written value of 0 is stored as 1.
- R8: An accepted write to 0x00C clears raw status and reloads the count from the reload register. This write takes priority over an expiry on the same cycle.
- R9: Bit 0 of the masked status (0x014) is the raw status AND control bit 0. irq_o equals the masked status bit. Raw status shows the pending state even while bit 0 is clear.
- R10: Control reads back only bits 1:0, with the upper bits zero. The interrupt-clear offset and unmapped offsets such as 0x020 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| cnt_tick | input | 1 | Count-enable pulse |
| irq_o | output | 1 | Interrupt, equal to masked status bit |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
A write or a tick changes state on the rising edge where it is presented, so the new value is visible at the ports one clock later. A read returns data in the same cycle as its address. The bench drives each stimulus on a falling edge and samples one nanosecond after the next falling edge, which is one register stage later. It reads the registers just after setting the address. It sweeps reload values 1 to 6 and counts ticks one at a time until raw status rises, so each period length is measured exactly as L+1. Cases that act on the same cycle, such as an interrupt clear arriving together with an expiry, are driven within one cycle and checked on the next.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 12'hC00;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_RST_BIT = 1;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int DW = 32,
    parameter logic [DW-1:0] KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     reload_q,
    output logic [1:0]        ctrl_q,
    output logic              locked_q,
    output logic              restart_o,
    output logic [DW-1:0]     restart_val_o,
    output logic              clr_o
);
    typedef struct packed {
        logic [DW-1:0] reload;
        logic [1:0]    ctrl;
        logic          locked;
    } cfg_t;

    cfg_t cur_q, nxt_d;
    logic wr_ok;

    always_comb begin
        nxt_d         = cur_q;
        wr_ok         = we && !cur_q.locked;
        restart_o     = 1'b0;
        clr_o         = 1'b0;
        restart_val_o = cur_q.reload;
        if (we && addr == OFF_KEY) begin
            nxt_d.locked = (wdata != KEY);
        end
        if (wr_ok) begin
            unique case (addr)
                OFF_RELOAD: begin
                    nxt_d.reload  = (wdata == '0) ? DW'(1) : wdata;
                    restart_o     = 1'b1;
                    restart_val_o = nxt_d.reload;
                end
                OFF_CTRL: nxt_d.ctrl = wdata[1:0];
                OFF_ICLR: begin
                    clr_o     = 1'b1;
                    restart_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.reload <= '1;
            cur_q.ctrl   <= '0;
            cur_q.locked <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign reload_q = cur_q.reload;
    assign ctrl_q   = cur_q.ctrl;
    assign locked_q = cur_q.locked;

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && we && addr != OFF_KEY) |=> ($stable(reload_q) && $stable(ctrl_q)));

    assert_key_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_KEY) |=> (locked_q == ($past(wdata) != KEY)));

    assert_reload_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload_q != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          rst_en,
    input  logic [CW-1:0] reload,
    input  logic          restart,
    input  logic [CW-1:0] restart_val,
    input  logic          clr,
    output logic [CW-1:0] cnt_q,
    output logic          raw_q,
    output logic          rst_q
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          raw;
        logic          rst;
    } core_t;

    core_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (restart) begin
            nxt_d.cnt = restart_val;
            if (clr) nxt_d.raw = 1'b0;
        end else if (run && tick) begin
            if (cur_q.cnt == '0) begin
                nxt_d.cnt = reload;
                nxt_d.raw = 1'b1;
                if (cur_q.raw && rst_en) nxt_d.rst = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.cnt <= '1;
            cur_q.raw <= 1'b0;
            cur_q.rst <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cnt_q = cur_q.cnt;
    assign raw_q = cur_q.raw;
    assign rst_q = cur_q.rst;

    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(run && tick)) |=> $stable(cnt_q));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !raw_q);

    assert_restart_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == $past(restart_val)));

    assert_rst_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> rst_q);

    assert_rst_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_q) |-> $past(raw_q && rst_en && run && tick));

    assert_expiry_sets_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && run && tick && cnt_q == '0) |=> (raw_q && cnt_q == $past(reload)));
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     reload,
    input  logic [DW-1:0]     cnt,
    input  logic [1:0]        ctrl,
    input  logic              raw,
    input  logic              locked,
    output logic [DW-1:0]     rdata
);
    always_comb begin
        unique case (addr)
            OFF_RELOAD: rdata = reload;
            OFF_COUNT:  rdata = cnt;
            OFF_CTRL:   rdata = {{(DW-2){1'b0}}, ctrl};
            OFF_RAW:    rdata = {{(DW-1){1'b0}}, raw};
            OFF_MASKED: rdata = {{(DW-1){1'b0}}, raw & ctrl[CTRL_RUN_BIT]};
            OFF_KEY:    rdata = {{(DW-1){1'b0}}, locked};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int DW = 32,
    parameter logic [DW-1:0] KEY = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              cnt_tick,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic [DW-1:0] reload_w, restart_val_w, cnt_w;
    logic [1:0]    ctrl_w;
    logic          locked_w, restart_w, clr_w, raw_w, rst_w;

    wdog_cfg #(.DW(DW), .KEY(KEY)) u_cfg (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .reload_q(reload_w), .ctrl_q(ctrl_w), .locked_q(locked_w),
        .restart_o(restart_w), .restart_val_o(restart_val_w), .clr_o(clr_w)
    );

    wdog_core #(.CW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
        .run(ctrl_w[CTRL_RUN_BIT]), .rst_en(ctrl_w[CTRL_RST_BIT]),
        .reload(reload_w), .restart(restart_w), .restart_val(restart_val_w),
        .clr(clr_w), .cnt_q(cnt_w), .raw_q(raw_w), .rst_q(rst_w)
    );

    wdog_rdmux #(.DW(DW)) u_rd (
        .addr(bus_addr), .reload(reload_w), .cnt(cnt_w), .ctrl(ctrl_w),
        .raw(raw_w), .locked(locked_w), .rdata(bus_rdata)
    );

    assign irq_o     = raw_w & ctrl_w[CTRL_RUN_BIT];
    assign sys_rst_o = rst_w;

    assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw_w && !(bus_addr == OFF_MASKED && bus_rdata[0] == 1'b0)));
endmodule

// File: tb/wdog_twostage_test.sv
`timescale 1ns/1ps
module wdog_twostage_test;
    localparam logic [11:0] A_RL = 12'h000, A_CNT = 12'h004, A_CTL = 12'h008,
                            A_CLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                            A_KEY = 12'hC00;
    localparam logic [31:0] KEYV = 32'h1ACCE551;

    logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, tick = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic irq, srst;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    wdog_twostage uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .cnt_tick(tick), .irq_o(irq), .sys_rst_o(srst)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; we = 1'b1; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        do_reset();
        // R1 reset state
        rd(A_KEY, v); chk("R1 key", v, 1);
        rd(A_RL, v);  chk("R1 reload", v, 32'hFFFFFFFF);
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_CNT, v); chk("R1 count", v, 32'hFFFFFFFF);
        rd(A_RAW, v); chk("R1 raw", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 srst", {31'b0, srst}, 0);

        // R3 locked writes ignored
        wr(A_RL, 5); wr(A_CTL, 3);
        rd(A_RL, v);  chk("R3 reload", v, 32'hFFFFFFFF);
        rd(A_CNT, v); chk("R3 count", v, 32'hFFFFFFFF);
        rd(A_CTL, v); chk("R3 ctrl", v, 0);

        // R2 unlock/lock
        wr(A_KEY, KEYV); rd(A_KEY, v); chk("R2 unlocked", v, 0);
        wr(A_KEY, 1);    rd(A_KEY, v); chk("R2 relock", v, 1);
        wr(A_KEY, KEYV);

        // R7 reload write, zero becomes one
        wr(A_RL, 0); rd(A_RL, v); chk("R7 zero->1", v, 1);
        rd(A_CNT, v); chk("R7 count", v, 1);
        wr(A_RL, 9); rd(A_CNT, v); chk("R7 count9", v, 9);

        // R10 ctrl readback and unmapped
        wr(A_CTL, 32'hFFFFFFFC); rd(A_CTL, v); chk("R10 ctrl", v, 0);
        rd(12'h020, v); chk("R10 unmapped", v, 0);
        rd(A_CLR, v);   chk("R10 iclr read", v, 0);

        // R4 hold while disabled, and without ticks
        tk(3); rd(A_CNT, v); chk("R4 disabled hold", v, 9);
        wr(A_CTL, 1); repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R4 no tick hold", v, 9);
        wr(A_CTL, 0);

        // R4/R5 sweep of period length
        for (int L = 1; L <= 6; L++) begin
            wr(A_RL, L); wr(A_CLR, 0); wr(A_CTL, 1);
            n = 0;
            for (int k = 0; k < 20; k++) begin
                tk(1); n++;
                if (n == 1) begin rd(A_CNT, v); chk("R4 first dec", v, L - 1); end
                rd(A_RAW, v);
                if (v[0]) break;
            end
            chk("R4 period", n, L + 1);
            rd(A_CNT, v); chk("R5 reloaded", v, L);
            chk("R9 irq", {31'b0, irq}, 1);
            wr(A_CTL, 0); wr(A_CLR, 0);
        end

        // R9 raw visible while disabled, masked off
        wr(A_RL, 2); wr(A_CTL, 1); tk(3); wr(A_CTL, 0);
        rd(A_RAW, v); chk("R9 raw", v, 1);
        rd(A_MSK, v); chk("R9 masked off", v, 0);
        chk("R9 irq off", {31'b0, irq}, 0);
        wr(A_CTL, 1); rd(A_MSK, v); chk("R9 masked on", v, 1);

        // R3 locked iclr ignored
        wr(A_KEY, 0); wr(A_CLR, 0);
        rd(A_RAW, v); chk("R3 iclr ignored", v, 1);
        wr(A_KEY, KEYV);

        // R6 no reset with bit1 clear
        tk(6); chk("R6 no rst bit1=0", {31'b0, srst}, 0);

        // R8 clear wins over same-cycle expiry
        wr(A_RL, 3); wr(A_CLR, 0); wr(A_CTL, 3);
        tk(4); rd(A_RAW, v); chk("R8 setup raw", v, 1);
        tk(3); rd(A_CNT, v); chk("R8 at zero", v, 0);
        @(negedge clk); tick = 1'b1; addr = A_CLR; we = 1'b1;
        @(negedge clk); tick = 1'b0; we = 1'b0;
        rd(A_RAW, v); chk("R8 raw cleared", v, 0);
        rd(A_CNT, v); chk("R8 reloaded", v, 3);
        chk("R8 no rst", {31'b0, srst}, 0);

        // R6 second expiry with pending irq -> sticky reset
        tk(4); chk("R6 after first", {31'b0, srst}, 0);
        tk(4); chk("R6 rst", {31'b0, srst}, 1);
        wr(A_CTL, 0); wr(A_CLR, 0); tk(2);
        chk("R6 sticky", {31'b0, srst}, 1);
        do_reset();
        chk("R1 srst cleared", {31'b0, srst}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule